// File: doc/BRIEF.md
# Prescaled Interval Timer

This block produces a periodic interrupt request from the system clock. A free-running 12-bit divider supplies four candidate count clocks. A small mode register picks one of them and gives software a self-clearing restart control. A CNT_W-bit counter, 8 bits by default, advances once per selected tick. Each time the counter wraps from all-ones to zero it raises a sticky interrupt request flag, so one interval is 2^CNT_W periods of the chosen count clock.

Software writes a 4-bit mode word. Bits 2..0 choose the count clock. Bit 3 is a restart request. When bit 3 is 1, the counter and the flag return to zero and timing starts again. The bit is never stored, so it reads back as 0. Software can also drop the flag alone through a dedicated clear input.

A two-state control machine sequences the restart. State CTL_RUN is the normal counting state. The transition RUN->CLEAR is taken on any write with bit 3 set. State CTL_CLEAR lasts one cycle and clears the counter and the flag. The transition CLEAR->RUN follows unless another restart write arrives, in which case the machine takes CLEAR->CLEAR.

Top module: `itmr_top`

## Requirements
- R1: After reset the count is 0, the flag is 0, the select code is 000 (the longest interval) and the mode read value is 4'b0000.
- R2: Let d be the divider value, which equals the number of clock edges since reset was released. The counter advances at the edge after each cycle in which d mod P equals P/2. P is 4096 for select code 000, 512 for code 011, 128 for code 101 and 32 for code 111.
- R3: Any select code other than 000, 011, 101 and 111 counts with P = 4096, the same as code 000.
- R4: The counter adds exactly one per tick. After 2^CNT_W ticks it wraps from all-ones to zero and keeps counting.
- R5: The flag rises at the edge where the counter wraps and stays at 1 until it is cleared.
- R6: A one-cycle pulse on irq_clr clears the flag at the next edge and leaves the count unchanged.
- R7: If irq_clr is high at the same edge where a wrap would set the flag, the flag ends up at 0.
- R8: A write with bit 3 at 1 loads the select code at its own edge. At the following edge the counter and the flag are both 0.
- R9: mode_rdata returns the last written bits 2..0 in bits 2..0, and returns 0 in bit 3.
- R10: A write with bit 3 at 0 changes only the select code. The count and the flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode write value: bit 3 is restart, bits 2..0 are the select code |
| mode_rdata | output | 4 | Mode read value |
| irq_clr | input | 1 | Software clear of the interrupt request flag |
| irq_flag | output | 1 | Interrupt request flag |
| count_val | output | CNT_W | Current counter value |

## Verification
The assertions take two things for granted. A count tick never lasts two cycles in a row, which holds because the fastest tap has a period of 32 cycles. Restart writes arrive as single-cycle strobes. The stimulus always releases mode_wr and irq_clr one cycle after raising them. It sets the counter width to 4 so that full wraps fit in a short run while every divider tap keeps its real period. Each write and each clear is timed relative to the predicted tick edges, so the collision case of R7 is reached exactly. The other cases stay clear of unintended coincidences.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int MODE_W   = 4;
    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 4;

    typedef enum logic [0:0] {
        CTL_RUN   = 1'b0,
        CTL_CLEAR = 1'b1
    } ctl_state_e;

    typedef enum logic [1:0] {
        TAP_SLOW    = 2'd0,
        TAP_MID     = 2'd1,
        TAP_FAST    = 2'd2,
        TAP_FASTEST = 2'd3
    } tap_sel_e;

    // Sparse select code to tap index; unlisted codes fall back to the slowest tap.
    function automatic tap_sel_e decode_sel(input logic [SEL_W-1:0] code);
        tap_sel_e t;
        case (code)
            3'b011:  t = TAP_MID;
            3'b101:  t = TAP_FAST;
            3'b111:  t = TAP_FASTEST;
            default: t = TAP_SLOW;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
    import itmr_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic     clk,
    input  logic     rst_n,
    input  tap_sel_e sel_i,
    output logic     tick_o
);

    // Tap bit positions derived from the divider width.
    function automatic int tap_pos(input int idx);
        int p;
        case (idx)
            0:       p = DIV_W - 1;
            1:       p = DIV_W - 4;
            2:       p = DIV_W - 6;
            default: p = DIV_W - 8;
        endcase
        return p;
    endfunction

    logic [DIV_W-1:0]    div_q;
    logic [NUM_TAPS-1:0] tap_now;
    logic [NUM_TAPS-1:0] tap_prev_q;
    logic [NUM_TAPS-1:0] tap_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q      <= '0;
            tap_prev_q <= '0;
        end else begin
            div_q      <= div_q + 1'b1;
            tap_prev_q <= tap_now;
        end
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign tap_now[g]  = div_q[tap_pos(g)];
        assign tap_rise[g] = tap_now[g] & ~tap_prev_q[g];
    end

    assign tick_o = tap_rise[sel_i];

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/itmr_mode_ctl.sv
module itmr_mode_ctl
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [MODE_W-1:0] wdata_i,
    output logic [MODE_W-1:0] rdata_o,
    output tap_sel_e          sel_o,
    output logic              restart_o
);

    ctl_state_e       state_q;
    ctl_state_e       state_d;
    logic [SEL_W-1:0] sel_q;
    logic             start_wr;

    assign start_wr = wr_i & wdata_i[MODE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTL_RUN;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_i) begin
                sel_q <= wdata_i[SEL_W-1:0];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_RUN:   state_d = start_wr ? CTL_CLEAR : CTL_RUN;
            CTL_CLEAR: state_d = start_wr ? CTL_CLEAR : CTL_RUN;
            default:   state_d = CTL_RUN;
        endcase
    end

    always_comb begin
        restart_o = 1'b0;
        unique case (state_q)
            CTL_RUN:   restart_o = 1'b0;
            CTL_CLEAR: restart_o = 1'b1;
            default:   restart_o = 1'b0;
        endcase
    end

    assign sel_o   = decode_sel(sel_q);
    assign rdata_o = {1'b0, sel_q};

    // R8
    clear_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_CLEAR && !start_wr) |=> (state_q == CTL_RUN));

    // R8
    restart_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> restart_o);

    // R9
    sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (rdata_o[SEL_W-1:0] == $past(wdata_i[SEL_W-1:0])));

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic             sw_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             wrap;

    assign wrap = tick_i & (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (restart_i || sw_clr_i) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0 && !flag_q));

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_q == CNT_MAX && !restart_i && !sw_clr_i) |=> flag_q);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !restart_i && !sw_clr_i) |=> flag_q);

    // R6
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr_i |=> !flag_q);

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !restart_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/itmr_top.sv
module itmr_top
    import itmr_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [3:0]       mode_wdata,
    output logic [3:0]       mode_rdata,
    input  logic             irq_clr,
    output logic             irq_flag,
    output logic [CNT_W-1:0] count_val
);

    tap_sel_e sel;
    logic     tick;
    logic     restart;

    itmr_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (mode_wr),
        .wdata_i   (mode_wdata),
        .rdata_o   (mode_rdata),
        .sel_o     (sel),
        .restart_o (restart)
    );

    itmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .tick_o (tick)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .restart_i (restart),
        .sw_clr_i  (irq_clr),
        .cnt_o     (count_val),
        .flag_o    (irq_flag)
    );

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq_flag);

endmodule

// File: tb/test_itmr_top.sv
`timescale 1ns/1ps
module test_itmr_top;

    localparam int TB_CNT_W = 4;
    localparam int K_CNT = 0;
    localparam int K_FLG = 1;
    localparam int K_RD  = 2;

    typedef struct {
        int    cyc;
        int    kind;
        int    exp;
        string tag;
    } item_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                mode_wr = 1'b0;
    logic [3:0]          mode_wdata = 4'd0;
    logic [3:0]          mode_rdata;
    logic                irq_clr = 1'b0;
    logic                irq_flag;
    logic [TB_CNT_W-1:0] count_val;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t q[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    itmr_top #(.CNT_W(TB_CNT_W)) i_itmr_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .mode_rdata (mode_rdata),
        .irq_clr    (irq_clr),
        .irq_flag   (irq_flag),
        .count_val  (count_val)
    );

    task automatic push(input int c, input int k, input int e, input string t);
        item_t it;
        it.cyc = c; it.kind = k; it.exp = e; it.tag = t;
        q.push_back(it);
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_write(input logic [3:0] v, output int w);
        mode_wdata = v;
        mode_wr    = 1'b1;
        @(posedge clk);
        #1;
        mode_wr = 1'b0;
        w = cyc;
    endtask

    // Earliest edge c >= from at which the counter advances for period p.
    function automatic int first_inc(input int from, input int p);
        int r;
        r = (from - 1) % p;
        return from + ((p / 2 - r + p) % p);
    endfunction

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: compares every expected item in its cycle
    always @(negedge clk) begin
        item_t keep[$];
        int    act;
        keep = {};
        foreach (q[i]) begin
            if (q[i].cyc == cyc) begin
                case (q[i].kind)
                    K_CNT:   act = int'(count_val);
                    K_FLG:   act = int'(irq_flag);
                    default: act = int'(mode_rdata);
                endcase
                checks++;
                if (act != q[i].exp) begin
                    errors++;
                    $display("FAIL %s kind %0d at cycle %0d: actual %0d expected %0d",
                             q[i].tag, q[i].kind, cyc, act, q[i].exp);
                end
            end else if (q[i].cyc < cyc) begin
                checks++;
                errors++;
                $display("FAIL %s stale item for cycle %0d: actual none expected %0d",
                         q[i].tag, q[i].cyc, q[i].exp);
            end else begin
                keep.push_back(q[i]);
            end
        end
        q = keep;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Driver
    initial begin
        int w;
        int c;
        int cw;
        int cw2;
        int cw3;
        int x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        push(1, K_CNT, 0, "R1");
        push(1, K_FLG, 0, "R1");
        push(1, K_RD, 0, "R1");
        // R2: default code 000 ticks every 4096 cycles
        push(2048, K_CNT, 0, "R2");
        push(2049, K_CNT, 1, "R2");
        push(6144, K_CNT, 1, "R2");
        push(6145, K_CNT, 2, "R2");
        wait_until(6146);

        // R10 / R3: unlisted code, no restart
        do_write(4'b0010, w);
        push(w, K_RD, 2, "R9");
        push(w + 1, K_CNT, 2, "R10");
        push(w + 1, K_FLG, 0, "R10");
        c = first_inc(w + 1, 4096);
        push(c - 1, K_CNT, 2, "R3");
        push(c, K_CNT, 3, "R3");
        wait_until(c + 2);

        // R8: restart with code 111
        do_write(4'b1111, w);
        push(w, K_RD, 7, "R9");
        push(w + 1, K_CNT, 0, "R8");
        push(w + 1, K_FLG, 0, "R8");
        c = first_inc(w + 2, 32);
        push(c - 1, K_CNT, 0, "R2");
        push(c, K_CNT, 1, "R2");
        cw = c + 15 * 32;
        push(cw - 1, K_CNT, TB_CNT_W == 4 ? 15 : 0, "R4");
        push(cw - 1, K_FLG, 0, "R5");
        push(cw, K_CNT, 0, "R4");
        push(cw, K_FLG, 1, "R5");
        push(cw + 32, K_CNT, 1, "R4");
        push(cw + 32, K_FLG, 1, "R5");
        wait_until(cw + 33);

        // R6: software clear
        irq_clr = 1'b1;
        @(posedge clk);
        #1;
        irq_clr = 1'b0;
        x = cyc;
        push(x, K_FLG, 0, "R6");
        push(x, K_CNT, 1, "R6");

        // R7: clear coincides with a wrap
        cw2 = cw + 16 * 32;
        push(cw2 - 1, K_FLG, 0, "R7");
        wait_until(cw2 - 1);
        irq_clr = 1'b1;
        @(posedge clk);
        #1;
        irq_clr = 1'b0;
        push(cw2, K_FLG, 0, "R7");
        push(cw2, K_CNT, 0, "R7");

        // Next wrap sets the flag again
        cw3 = cw2 + 16 * 32;
        push(cw3, K_FLG, 1, "R5");
        wait_until(cw3 + 3);

        // R10: write without restart keeps flag and count
        do_write(4'b0111, w);
        push(w + 1, K_FLG, 1, "R10");
        push(w + 1, K_CNT, 0, "R10");
        wait_until(w + 2);

        // R8: restart clears a set flag, switch to code 011
        do_write(4'b1011, w);
        push(w, K_RD, 3, "R9");
        push(w + 1, K_CNT, 0, "R8");
        push(w + 1, K_FLG, 0, "R8");
        c = first_inc(w + 2, 512);
        push(c - 1, K_CNT, 0, "R2");
        push(c, K_CNT, 1, "R2");
        push(c + 511, K_CNT, 1, "R2");
        push(c + 512, K_CNT, 2, "R2");
        wait_until(c + 514);

        // R2: code 101
        do_write(4'b1101, w);
        push(w, K_RD, 5, "R9");
        c = first_inc(w + 2, 128);
        push(c - 1, K_CNT, 0, "R2");
        push(c, K_CNT, 1, "R2");
        push(c + 127, K_CNT, 1, "R2");
        push(c + 128, K_CNT, 2, "R2");
        wait_until(c + 130);

        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
        end
        finish_run();
    end

endmodule